// File: doc/BRIEF.md
# Byte-Bus Serial Transmitter

This block is the transmit half of an asynchronous serial port that sits on a small 8-bit register bus. Software sets the bit time through a 12-bit divisor and a speed-doubling bit. It picks a character length of 5 to 9 bits and one or two stop bits, then writes characters into a one-deep holding buffer. The block moves each buffered character into a shift register, sends it LSB first on a single line that idles high, and keeps two status flags. One flag shows that the holding buffer can take a new character. The other shows that the line has gone quiet with nothing left to send.

Each flag drives an interrupt request that has its own enable. An interrupt controller outside the block answers a request with a one-cycle acknowledge pulse, and that pulse clears the matching flag. The done flag can also be cleared by writing a 1 to its bit. Register reads are combinational and have no side effects.

Top module: `ser_tx_unit`

## Requirements
- R1: One bit lasts (DIV+1)×16 clock cycles, or (DIV+1)×8 cycles when the speed bit (address 0, bit 1) is set. DIV is {address 4 bits 3:0, address 3 bits 7:0}. A frame's start bit begins one cycle after the write that loads an idle transmitter.
- R2: The character length code is {address 1 bit 2, address 2 bits 2:1}. Codes 0 to 3 give 5 to 8 data bits, and codes 4 to 7 give 9 data bits. In 9-bit frames the ninth bit is address 1 bit 0, captured when the data register is written.
- R3: A frame is one low start bit, then the data bits LSB first, then one high stop bit, or two when address 2 bit 3 is set. The line is high whenever no frame is in progress.
- R4: A write to address 1 that takes the enable bit (bit 3) from 0 to 1 sets the empty flag (address 0, bit 5).
- R5: A write to the data register (address 5) while enabled fills the buffer and clears the empty flag. The flag sets again when the buffer moves to the shift register, one cycle later if the line is idle. A data write while disabled is ignored: the line stays high and the flags do not change.
- R6: The done flag (address 0, bit 6) sets when the last stop bit ends and the buffer is empty. Writing 1 to that bit clears it; writing 0 leaves it.
- R7: empty_irq is high exactly when the empty flag and its enable (address 1, bit 5) are both set. done_irq is high exactly when the done flag and its enable (address 1, bit 6) are both set.
- R8: A pulse on empty_ack clears the empty flag, and a pulse on done_ack clears the done flag. If a set event falls in the same cycle, the set wins.
- R9: A character buffered during a frame starts right after that frame's last stop bit, with no idle bit between, and the done flag stays clear between the two frames.
- R10: After reset every register reads 0, both requests are low and the line is high. Reads return only the implemented bits: unused bits and the data register read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data, 0 when not selected |
| empty_ack | input | 1 | Buffer-empty interrupt taken |
| done_ack | input | 1 | Transmit-done interrupt taken |
| empty_irq | output | 1 | Buffer-empty interrupt request |
| done_irq | output | 1 | Transmit-done interrupt request |
| txd | output | 1 | Serial output line |

## Verification
The bench walks a set of frames that cover every length code, including the reserved ones, both stop-bit settings, both speeds and a divisor that uses the high byte. A divider off by one cycle, or one that ignores the speed bit or the high byte, shifts the mid-bit samples into the wrong bits. A decoder that treats reserved codes as short frames drops the ninth bit. The bench also writes a second character while the first is on the line. A design that idles between the frames misaligns the second frame, and a design that raises done early shows the flag in the gap. Further checks confirm that a data write while disabled sends nothing, and that acknowledges and a write of 0 to the done bit have exactly their stated effects.

// File: rtl/ser_tx_pkg.sv
package ser_tx_pkg;

    localparam int BYTE_W    = 8;
    localparam int ADDR_W    = 3;
    localparam int DIV_W     = 12;
    localparam int DIV_HI_W  = DIV_W - BYTE_W;
    localparam int CHR_MAX   = 9;
    localparam int FRM_W     = CHR_MAX + 3;
    localparam int BIT_CNT_W = $clog2(FRM_W);
    localparam int SUB_W     = 4;
    localparam int CODE_W    = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_STAT  = 3'd0,
        A_CTLB  = 3'd1,
        A_CTLC  = 3'd2,
        A_DIVLO = 3'd3,
        A_DIVHI = 3'd4,
        A_DATA  = 3'd5
    } reg_sel_e;

    // bit positions in the status register
    localparam int B_DONE  = 6;
    localparam int B_EMPTY = 5;
    localparam int B_DBL   = 1;
    // bit positions in control register B
    localparam int B_EN_DONE  = 6;
    localparam int B_EN_EMPTY = 5;
    localparam int B_TXEN     = 3;
    localparam int B_SZ2      = 2;
    localparam int B_BIT8     = 0;
    // bit positions in control register C
    localparam int B_STOP2 = 3;
    localparam int B_SZ_LO = 1;

    typedef struct packed {
        logic              dbl;
        logic [DIV_W-1:0]  div;
        logic [CODE_W-1:0] size_code;
        logic              two_stop;
        logic              tx_en;
        logic              en_empty;
        logic              en_done;
        logic              bit8;
    } cfg_t;

    function automatic logic [3:0] char_bits(input logic [CODE_W-1:0] code);
        return code[2] ? 4'd9 : (4'd5 + {2'b00, code[1:0]});
    endfunction

    // start bit at position 0, data above it, idle-high padding elsewhere
    function automatic logic [FRM_W-1:0] frame_image(input logic [CHR_MAX-1:0] d,
                                                     input logic [3:0] n);
        logic [FRM_W-1:0] f;
        f    = '1;
        f[0] = 1'b0;
        for (int i = 0; i < CHR_MAX; i++) begin
            if (i < int'(n)) f[i+1] = d[i];
        end
        return f;
    endfunction

    // index of the final bit of a frame (frame length minus one)
    function automatic logic [BIT_CNT_W-1:0] frame_last(input logic [3:0] n,
                                                        input logic two);
        return BIT_CNT_W'(n) + (two ? BIT_CNT_W'(2) : BIT_CNT_W'(1));
    endfunction

endpackage

// File: rtl/ser_tx_baud.sv
module ser_tx_baud
    import ser_tx_pkg::*;
#(
    parameter int DW = DIV_W,
    parameter int SW = SUB_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          restart,
    input  logic [DW-1:0] div,
    input  logic          dbl,
    output logic          bit_end
);
    localparam logic [SW-1:0] SUB_NORM = SW'((1 << SW) - 1);
    localparam logic [SW-1:0] SUB_FAST = SW'((1 << (SW - 1)) - 1);

    logic [DW-1:0] pre;
    logic [SW-1:0] sub;
    logic [SW-1:0] sub_top;
    logic          pre_wrap;
    logic          sub_wrap;

    assign sub_top  = dbl ? SUB_FAST : SUB_NORM;
    assign pre_wrap = (pre >= div);
    assign sub_wrap = (sub >= sub_top);
    assign bit_end  = run & pre_wrap & sub_wrap;

    always_ff @(posedge clk) begin
        if (rst || restart || !run) begin
            pre <= '0;
            sub <= '0;
        end else if (pre_wrap) begin
            pre <= '0;
            sub <= sub_wrap ? '0 : sub + 1'b1;
        end else begin
            pre <= pre + 1'b1;
        end
    end

    // shortest bit is eight cycles, so two ends never touch
    p_bit_gap_r1: assert property (@(posedge clk) disable iff (rst)
        bit_end |=> !bit_end);

    // a restart always begins a full bit period
    p_restart_r1: assert property (@(posedge clk) disable iff (rst)
        (restart && run) |=> !bit_end);

endmodule

// File: rtl/ser_tx_shift.sv
module ser_tx_shift
    import ser_tx_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               bit_end,
    input  logic               buf_full,
    input  logic [CHR_MAX-1:0] buf_data,
    input  logic [CODE_W-1:0]  size_code,
    input  logic               two_stop,
    output logic               load,
    output logic               frame_end,
    output logic               busy,
    output logic               txd
);
    logic [FRM_W-1:0]     shreg;
    logic [BIT_CNT_W-1:0] bitcnt;
    logic [3:0]           nbits;

    assign nbits     = char_bits(size_code);
    assign frame_end = busy && bit_end && (bitcnt == '0);
    assign load      = buf_full && (!busy || frame_end);
    assign txd       = shreg[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg  <= '1;
            bitcnt <= '0;
            busy   <= 1'b0;
        end else if (load) begin
            shreg  <= frame_image(buf_data, nbits);
            bitcnt <= frame_last(nbits, two_stop);
            busy   <= 1'b1;
        end else if (busy && bit_end) begin
            shreg <= {1'b1, shreg[FRM_W-1:1]};
            if (frame_end) busy   <= 1'b0;
            else           bitcnt <= bitcnt - 1'b1;
        end
    end

    p_idle_high_r3: assert property (@(posedge clk) disable iff (rst)
        !busy |-> txd);

    p_start_low_r3: assert property (@(posedge clk) disable iff (rst)
        load |=> (!txd && busy));

    p_back_to_back_r9: assert property (@(posedge clk) disable iff (rst)
        (frame_end && buf_full) |=> busy);

endmodule

// File: rtl/ser_tx_regs.sv
module ser_tx_regs
    import ser_tx_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [BYTE_W-1:0]  bus_wdata,
    output logic [BYTE_W-1:0]  bus_rdata,
    input  logic               empty_ack,
    input  logic               done_ack,
    input  logic               load_evt,
    input  logic               frame_end,
    output cfg_t               cfg,
    output logic               buf_full,
    output logic [CHR_MAX-1:0] buf_data,
    output logic               empty_irq,
    output logic               done_irq
);
    cfg_t cfg_q;
    logic empty_flag;
    logic done_flag;
    logic wr_any, wr_stat, wr_ctlb, wr_ctlc, wr_divlo, wr_divhi, wr_data;
    logic accept_data;
    logic txen_rise;
    logic set_empty;
    logic set_done;

    assign wr_any   = bus_sel && bus_wr;
    assign wr_stat  = wr_any && (bus_addr == A_STAT);
    assign wr_ctlb  = wr_any && (bus_addr == A_CTLB);
    assign wr_ctlc  = wr_any && (bus_addr == A_CTLC);
    assign wr_divlo = wr_any && (bus_addr == A_DIVLO);
    assign wr_divhi = wr_any && (bus_addr == A_DIVHI);
    assign wr_data  = wr_any && (bus_addr == A_DATA);

    assign accept_data = wr_data && cfg_q.tx_en;
    assign txen_rise   = wr_ctlb && bus_wdata[B_TXEN] && !cfg_q.tx_en;
    assign set_empty   = load_evt || txen_rise;
    assign set_done    = frame_end && !buf_full;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q      <= '0;
            buf_full   <= 1'b0;
            buf_data   <= '0;
            empty_flag <= 1'b0;
            done_flag  <= 1'b0;
        end else begin
            if (wr_stat) cfg_q.dbl <= bus_wdata[B_DBL];
            if (wr_ctlb) begin
                cfg_q.en_done      <= bus_wdata[B_EN_DONE];
                cfg_q.en_empty     <= bus_wdata[B_EN_EMPTY];
                cfg_q.tx_en        <= bus_wdata[B_TXEN];
                cfg_q.size_code[2] <= bus_wdata[B_SZ2];
                cfg_q.bit8         <= bus_wdata[B_BIT8];
            end
            if (wr_ctlc) begin
                cfg_q.two_stop       <= bus_wdata[B_STOP2];
                cfg_q.size_code[1:0] <= bus_wdata[B_SZ_LO+1:B_SZ_LO];
            end
            if (wr_divlo) cfg_q.div[BYTE_W-1:0]     <= bus_wdata;
            if (wr_divhi) cfg_q.div[DIV_W-1:BYTE_W] <= bus_wdata[DIV_HI_W-1:0];

            // holding buffer: a new write wins over the move to the shifter
            if (load_evt) buf_full <= 1'b0;
            if (accept_data) begin
                buf_full <= 1'b1;
                buf_data <= {cfg_q.bit8, bus_wdata};
            end

            // empty flag: set beats acknowledge, a new character beats both
            if (set_empty)      empty_flag <= 1'b1;
            else if (empty_ack) empty_flag <= 1'b0;
            if (accept_data)    empty_flag <= 1'b0;

            if (set_done) done_flag <= 1'b1;
            else if ((wr_stat && bus_wdata[B_DONE]) || done_ack) done_flag <= 1'b0;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_sel) begin
            case (bus_addr)
                A_STAT: begin
                    bus_rdata[B_DONE]  = done_flag;
                    bus_rdata[B_EMPTY] = empty_flag;
                    bus_rdata[B_DBL]   = cfg_q.dbl;
                end
                A_CTLB: begin
                    bus_rdata[B_EN_DONE]  = cfg_q.en_done;
                    bus_rdata[B_EN_EMPTY] = cfg_q.en_empty;
                    bus_rdata[B_TXEN]     = cfg_q.tx_en;
                    bus_rdata[B_SZ2]      = cfg_q.size_code[2];
                    bus_rdata[B_BIT8]     = cfg_q.bit8;
                end
                A_CTLC: begin
                    bus_rdata[B_STOP2]              = cfg_q.two_stop;
                    bus_rdata[B_SZ_LO+1:B_SZ_LO]    = cfg_q.size_code[1:0];
                end
                A_DIVLO: bus_rdata = cfg_q.div[BYTE_W-1:0];
                A_DIVHI: bus_rdata = BYTE_W'(cfg_q.div[DIV_W-1:BYTE_W]);
                default: bus_rdata = '0;
            endcase
        end
    end

    assign cfg       = cfg_q;
    assign empty_irq = empty_flag && cfg_q.en_empty;
    assign done_irq  = done_flag && cfg_q.en_done;

    p_txen_rise_r4: assert property (@(posedge clk) disable iff (rst)
        txen_rise |=> empty_flag);

    p_data_clears_r5: assert property (@(posedge clk) disable iff (rst)
        accept_data |=> (!empty_flag && buf_full));

    p_ignored_data_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_data && !cfg_q.tx_en && !buf_full) |=> !buf_full);

    p_w1c_done_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_stat && bus_wdata[B_DONE] && !set_done) |=> !done_flag);

    p_empty_ack_r8: assert property (@(posedge clk) disable iff (rst)
        (empty_ack && !load_evt && !wr_ctlb) |=> !empty_flag);

    p_done_ack_r8: assert property (@(posedge clk) disable iff (rst)
        (done_ack && !frame_end) |=> !done_flag);

endmodule

// File: rtl/ser_tx_unit.sv
module ser_tx_unit
    import ser_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              empty_ack,
    input  logic              done_ack,
    output logic              empty_irq,
    output logic              done_irq,
    output logic              txd
);
    cfg_t               cfg;
    logic               buf_full;
    logic [CHR_MAX-1:0] buf_data;
    logic               load;
    logic               frame_end;
    logic               busy;
    logic               bit_end;

    ser_tx_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .empty_ack (empty_ack),
        .done_ack  (done_ack),
        .load_evt  (load),
        .frame_end (frame_end),
        .cfg       (cfg),
        .buf_full  (buf_full),
        .buf_data  (buf_data),
        .empty_irq (empty_irq),
        .done_irq  (done_irq)
    );

    ser_tx_baud #(.DW(DIV_W), .SW(SUB_W)) u_baud (
        .clk     (clk),
        .rst     (rst),
        .run     (busy),
        .restart (load),
        .div     (cfg.div),
        .dbl     (cfg.dbl),
        .bit_end (bit_end)
    );

    ser_tx_shift u_shift (
        .clk       (clk),
        .rst       (rst),
        .bit_end   (bit_end),
        .buf_full  (buf_full),
        .buf_data  (buf_data),
        .size_code (cfg.size_code),
        .two_stop  (cfg.two_stop),
        .load      (load),
        .frame_end (frame_end),
        .busy      (busy),
        .txd       (txd)
    );

endmodule

// File: tb/test_ser_tx_unit.sv
module test_ser_tx_unit;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_sel = 1'b0;
    logic       bus_wr = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       empty_ack = 1'b0;
    logic       done_ack = 1'b0;
    logic       empty_irq;
    logic       done_irq;
    logic       txd;

    int n_tests = 0;
    int n_fail  = 0;
    bit ended   = 1'b0;

    localparam logic [2:0] RS = 3'd0, RB = 3'd1, RC = 3'd2, RL = 3'd3, RH = 3'd4, RD = 3'd5;

    typedef struct packed {
        logic [11:0] div;
        logic        dbl;
        logic [2:0]  code;
        logic        stop2;
        logic [8:0]  data;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{12'd0,     1'b0, 3'd3, 1'b0, 9'h0A5},
        '{12'd1,     1'b1, 3'd0, 1'b1, 9'h013},
        '{12'd2,     1'b0, 3'd1, 1'b0, 9'h02C},
        '{12'd0,     1'b1, 3'd2, 1'b1, 9'h055},
        '{12'd0,     1'b0, 3'd7, 1'b0, 9'h1C3},
        '{12'd3,     1'b1, 3'd5, 1'b1, 9'h10F},
        '{12'h101,   1'b1, 3'd0, 1'b0, 9'h015}
    };

    always #2 clk = ~clk;

    ser_tx_unit i_ser_tx_unit (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .empty_ack (empty_ack),
        .done_ack  (done_ack),
        .empty_irq (empty_irq),
        .done_irq  (done_irq),
        .txd       (txd)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        bus_addr = a; bus_sel = 1'b1;
        #1;
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic sample_frame(input int nb, input int len, output logic [11:0] got);
        got = '1;
        for (int j = 0; j < nb; j++) begin
            got[j] = txd;
            repeat (len) @(negedge clk);
        end
    endtask

    function automatic int nbits_of(input logic [2:0] code);
        return (code >= 3'd4) ? 9 : 5 + int'(code);
    endfunction

    function automatic int bitlen_of(input logic [11:0] div, input logic dbl);
        return (int'(div) + 1) * (dbl ? 8 : 16);
    endfunction

    function automatic logic [11:0] exp_frame(input logic [8:0] d, input int n);
        logic [11:0] f;
        for (int j = 0; j < 12; j++) begin
            if (j == 0)      f[j] = 1'b0;
            else if (j <= n) f[j] = d[j-1];
            else             f[j] = 1'b1;
        end
        return f;
    endfunction

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0]  s;
        logic [11:0] got;
        int          lows;

        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R10 reset state
        chk("R10 txd idle after reset", 32'(txd), 32'd1);
        chk("R10 empty_irq after reset", 32'(empty_irq), 32'd0);
        chk("R10 done_irq after reset", 32'(done_irq), 32'd0);
        rd(RS, s); chk("R10 status after reset", 32'(s), 32'h00);
        rd(RB, s); chk("R10 ctrl B after reset", 32'(s), 32'h00);

        // R5 data write while disabled is ignored
        wr(RD, 8'h00);
        lows = 0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (txd == 1'b0) lows++;
        end
        chk("R5 disabled write sends nothing", 32'(lows), 32'd0);
        rd(RS, s); chk("R5 disabled write leaves flags", 32'(s), 32'h00);

        // R4 enable rise sets empty
        wr(RB, 8'h08);
        rd(RS, s); chk("R4 enable rise sets empty", 32'(s), 32'h20);

        // R10 readback masks
        wr(RC, 8'hFF); rd(RC, s); chk("R10 ctrl C implemented bits", 32'(s), 32'h0E);
        wr(RH, 8'hFF); rd(RH, s); chk("R10 divisor high masked", 32'(s), 32'h0F);
        rd(RD, s); chk("R10 data register reads zero", 32'(s), 32'h00);
        wr(RH, 8'h00);

        // vector table: R1 R2 R3 R5 R6 R7
        for (int i = 0; i < NV; i++) begin
            vec_t v;
            int   len, n, fl;
            v   = VECS[i];
            len = bitlen_of(v.div, v.dbl);
            n   = nbits_of(v.code);
            fl  = 1 + n + (v.stop2 ? 2 : 1);
            wr(RS, 8'h40 | {6'b0, v.dbl, 1'b0});
            rd(RS, s); chk("R6 write one clears done", 32'(s[6]), 32'd0);
            wr(RL, v.div[7:0]);
            wr(RH, {4'b0, v.div[11:8]});
            wr(RC, {4'b0, v.stop2, v.code[1:0], 1'b0});
            wr(RB, {4'b0000, 1'b1, v.code[2], 1'b0, v.data[8]});
            wr(RD, v.data[7:0]);
            rd(RS, s); chk("R5 data write clears empty", 32'(s[5]), 32'd0);
            @(negedge clk);
            rd(RS, s); chk("R5 empty set on move to shifter", 32'(s[5]), 32'd1);
            repeat (len / 2) @(negedge clk);
            sample_frame(fl, len, got);
            chk($sformatf("R1 R2 R3 frame vector %0d", i), 32'(got), 32'(exp_frame(v.data, n)));
            rd(RS, s); chk("R6 done set after last stop", 32'(s[6]), 32'd1);
            chk("R7 empty_irq gated off", 32'(empty_irq), 32'd0);
            chk("R7 done_irq gated off", 32'(done_irq), 32'd0);
        end

        // R1 exact start timing at 16 cycles per bit
        wr(RS, 8'h40);
        wr(RL, 8'h00);
        wr(RH, 8'h00);
        wr(RC, 8'h06);
        wr(RB, 8'h08);
        wr(RD, 8'hA5);
        chk("R1 line high in write cycle", 32'(txd), 32'd1);
        @(negedge clk);
        chk("R1 start one cycle after write", 32'(txd), 32'd0);
        repeat (15) @(negedge clk);
        chk("R1 start still low in last cycle", 32'(txd), 32'd0);
        @(negedge clk);
        chk("R1 first data bit after 16 cycles", 32'(txd), 32'd1);
        repeat (200) @(negedge clk);

        // R9 back-to-back frames
        wr(RS, 8'h40);
        wr(RD, 8'h3A);
        wr(RD, 8'hC5);
        rd(RS, s); chk("R5 empty clear while buffer holds", 32'(s[5]), 32'd0);
        repeat (7) @(negedge clk);
        sample_frame(10, 16, got);
        chk("R9 first frame", 32'(got), 32'(exp_frame(9'h03A, 8)));
        rd(RS, s); chk("R9 done clear between frames", 32'(s[6]), 32'd0);
        sample_frame(10, 16, got);
        chk("R9 second frame follows at once", 32'(got), 32'(exp_frame(9'h0C5, 8)));
        rd(RS, s); chk("R9 done after second frame", 32'(s[6]), 32'd1);

        // R7 and R8 interrupt requests and acknowledges
        wr(RB, 8'h68);
        chk("R7 empty_irq with enable", 32'(empty_irq), 32'd1);
        chk("R7 done_irq with enable", 32'(done_irq), 32'd1);
        @(negedge clk); empty_ack = 1'b1;
        @(negedge clk); empty_ack = 1'b0;
        chk("R8 empty ack drops request", 32'(empty_irq), 32'd0);
        rd(RS, s); chk("R8 empty ack clears flag", 32'(s[5]), 32'd0);
        chk("R8 empty ack leaves done", 32'(done_irq), 32'd1);
        wr(RS, 8'h00);
        rd(RS, s); chk("R6 write zero keeps done", 32'(s[6]), 32'd1);
        @(negedge clk); done_ack = 1'b1;
        @(negedge clk); done_ack = 1'b0;
        chk("R8 done ack drops request", 32'(done_irq), 32'd0);
        rd(RS, s); chk("R8 done ack clears flag", 32'(s[6]), 32'd0);

        // R4 second enable rise
        wr(RB, 8'h00);
        rd(RS, s); chk("R4 flag clear before rise", 32'(s[5]), 32'd0);
        wr(RB, 8'h08);
        rd(RS, s); chk("R4 second enable rise sets empty", 32'(s[5]), 32'd1);

        finish_run();
    end

endmodule